// File: doc/BRIEF.md
# Systolic GF(2^m) Multiplier over an All-One Field Polynomial

This block multiplies two elements of GF(2^m) in polynomial basis, where the field is generated by the all-one polynomial Q(z) = z^m + z^(m-1) + ... + z + 1. Operand words `a_in` and `b_in` may be applied on every clock. Each `product` is `a_in * b_in mod Q(z)`, and it appears a fixed `M` cycles later. A valid flag travels through the pipeline with the data. Bit k of every operand and result word is the coefficient of z^k.

The datapath is a linear systolic chain. An entry cell forms A·alpha and the first partial sum. Then come M-2 identical processing elements. Element i takes the operand word multiplied by alpha^(i+1) and adds it under control of operand bit i+1. Because alpha^(m+1) = 1, intermediate sums are held as (m+1)-bit words, and multiplying by alpha is only a cyclic rotation done by wiring. At the end, an exit cell folds the top coefficient into the lower bits, adds b0·A, and presents the result. The bits of B are skewed by per-bit delay lines so that each bit meets its own data wave. `M` must be a value for which the all-one polynomial is irreducible (4, 10, 12, 18, ...). Elaboration rejects any other value.

The block has no state machine. Control is only the valid bit, which moves one stage on each clock.

Top module: `gfa_mult`

## Requirements
- R1: For every operand pair accepted with `in_valid` high, `product` equals the polynomial product of `a_in` and `b_in` reduced modulo the all-one polynomial of degree `M`, where bit k of each word is the coefficient of z^k.
- R2: `out_valid` equals `in_valid` from exactly `M` clock cycles earlier, and the product of that pair is present in the same cycle.
- R3: Operand pairs may be applied on consecutive cycles with no gap, and every one of them yields its own correct product.
- R4: While synchronous active-high `rst` is sampled high at a clock edge, the following cycle shows `out_valid` low and `product` all zeros, including when valid data was in flight.
- R5: When `b_in` equals 1 (only bit 0 set), the product equals `a_in`. When `a_in` equals 1, the product equals `b_in`.
- R6: When either operand is zero, the product is zero.
- R7: When both operands are all ones, the product has only bit `M-1` set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst | input | 1 | Synchronous active-high reset; clears every pipeline register |
| in_valid | input | 1 | Marks the operand pair in this cycle as valid |
| a_in | input | M | Operand A, bit k = coefficient of z^k |
| b_in | input | M | Operand B, bit k = coefficient of z^k |
| out_valid | output | 1 | Marks `product` as the result of a pair accepted M cycles earlier |
| product | output | M | A·B mod Q(z) |

## Verification
A wrong rotation or tap in element i corrupts only products where operand bit i+1 is set. That error reaches `product` exactly `M` cycles after the pair enters, so random and structured operand words locate it quickly. A broken skew delay for one B bit shows as wrong results that depend on the neighbouring pair's bits, and back-to-back streams expose this at once. A stage whose valid or reset handling is wrong shows as `out_valid` off by a cycle, or as nonzero output right after a reset edge.

// File: rtl/gfa_pkg.sv
`timescale 1ns/1ps
package gfa_pkg;

    // True when z^m + ... + z + 1 is irreducible over GF(2):
    // m+1 is prime and 2 has multiplicative order m modulo m+1.
    function automatic bit aop_ok(input int m);
        int n;
        int r;
        n = m + 1;
        if (m < 4) return 1'b0;
        for (int d = 2; d < n; d++) begin
            if (n % d == 0) return 1'b0;
        end
        r = 1;
        for (int k = 1; k < m; k++) begin
            r = (r * 2) % n;
            if (r == 1) return 1'b0;
        end
        return 1'b1;
    endfunction

endpackage

// File: rtl/gfa_delay.sv
`timescale 1ns/1ps
module gfa_delay #(
    parameter int DEPTH = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [DEPTH-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '0;
        end else begin
            sr[0] <= d;
            for (int k = 1; k < DEPTH; k++) begin
                sr[k] <= sr[k-1];
            end
        end
    end

    assign q = sr[DEPTH-1];
endmodule

// File: rtl/gfa_entry_cell.sv
`timescale 1ns/1ps
module gfa_entry_cell #(
    parameter int M = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         v_in,
    input  logic [M-1:0] a_in,
    input  logic         b_bit,
    output logic         v_q,
    output logic [M-1:0] a_q,
    output logic [M:0]   s_q
);
    // A*alpha is A shifted up one place into M+1 bits; gated by operand bit 1.
    logic [M:0] s_n;
    assign s_n = {a_in & {M{b_bit}}, 1'b0};

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q <= 1'b0;
            a_q <= '0;
            s_q <= '0;
        end else begin
            v_q <= v_in;
            a_q <= a_in;
            s_q <= s_n;
        end
    end
endmodule

// File: rtl/gfa_pe.sv
`timescale 1ns/1ps
module gfa_pe #(
    parameter int M     = 10,
    parameter int SHIFT = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         v_in,
    input  logic [M-1:0] a_in,
    input  logic [M:0]   s_in,
    input  logic         b_bit,
    output logic         v_q,
    output logic [M-1:0] a_q,
    output logic [M:0]   s_q
);
    localparam int W = M + 1;

    // A*alpha^(SHIFT+1) in redundant form: A*alpha rotated left by SHIFT
    // over W positions. Position SHIFT of that word is always zero, so the
    // partial-sum bit there passes through with no gate.
    logic [M:0] s_n;
    assign s_n[SHIFT] = s_in[SHIFT];

    for (genvar j = 1; j <= M; j++) begin : g_tap
        localparam int POS = (j + SHIFT) % W;
        assign s_n[POS] = s_in[POS] ^ (a_in[j-1] & b_bit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q <= 1'b0;
            a_q <= '0;
            s_q <= '0;
        end else begin
            v_q <= v_in;
            a_q <= a_in;
            s_q <= s_n;
        end
    end
endmodule

// File: rtl/gfa_exit_cell.sv
`timescale 1ns/1ps
module gfa_exit_cell #(
    parameter int M = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         v_in,
    input  logic [M-1:0] a_in,
    input  logic [M:0]   s_in,
    input  logic         b_bit,
    output logic         v_out,
    output logic [M-1:0] prod
);
    // z^m == z^(m-1) + ... + 1 : fold the top coefficient into every lower bit.
    logic [M-1:0] red;
    assign red = s_in[M-1:0] ^ {M{s_in[M]}};

    logic [M-1:0] red_q;
    logic [M-1:0] a_q;
    logic         b0_q;
    logic         v_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            red_q <= '0;
            a_q   <= '0;
            b0_q  <= 1'b0;
            v_q   <= 1'b0;
        end else begin
            red_q <= red;
            a_q   <= a_in;
            b0_q  <= b_bit;
            v_q   <= v_in;
        end
    end

    assign prod  = red_q ^ (a_q & {M{b0_q}});
    assign v_out = v_q;
endmodule

// File: rtl/gfa_mult.sv
`timescale 1ns/1ps
module gfa_mult #(
    parameter int M = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [M-1:0] a_in,
    input  logic [M-1:0] b_in,
    output logic         out_valid,
    output logic [M-1:0] product
);
    localparam int NPE = M - 2;

    if (!gfa_pkg::aop_ok(M)) begin : g_bad_m
        $error("gfa_mult: all-one polynomial of this degree is not irreducible");
    end

    // Operand-bit skew: bit k (k>=1) meets stage k-1; bit 0 meets the exit cell.
    logic [M-1:0] b_sk;
    for (genvar k = 0; k < M; k++) begin : g_skew
        if (k == 1) begin : g_direct
            assign b_sk[k] = b_in[k];
        end else begin : g_delayed
            localparam int D = (k == 0) ? (M - 1) : (k - 1);
            gfa_delay #(.DEPTH(D)) u_dly (
                .clk (clk),
                .rst (rst),
                .d   (b_in[k]),
                .q   (b_sk[k])
            );
        end
    end

    // Stage 0 is the entry cell, stage i is element i.
    logic         v_ch [0:NPE];
    logic [M-1:0] a_ch [0:NPE];
    logic [M:0]   s_ch [0:NPE];

    gfa_entry_cell #(.M(M)) u_entry (
        .clk   (clk),
        .rst   (rst),
        .v_in  (in_valid),
        .a_in  (a_in),
        .b_bit (b_sk[1]),
        .v_q   (v_ch[0]),
        .a_q   (a_ch[0]),
        .s_q   (s_ch[0])
    );

    for (genvar i = 1; i <= NPE; i++) begin : g_pe
        gfa_pe #(.M(M), .SHIFT(i)) u_pe (
            .clk   (clk),
            .rst   (rst),
            .v_in  (v_ch[i-1]),
            .a_in  (a_ch[i-1]),
            .s_in  (s_ch[i-1]),
            .b_bit (b_sk[i+1]),
            .v_q   (v_ch[i]),
            .a_q   (a_ch[i]),
            .s_q   (s_ch[i])
        );
    end

    gfa_exit_cell #(.M(M)) u_exit (
        .clk   (clk),
        .rst   (rst),
        .v_in  (v_ch[NPE]),
        .a_in  (a_ch[NPE]),
        .s_in  (s_ch[NPE]),
        .b_bit (b_sk[0]),
        .v_out (out_valid),
        .prod  (product)
    );
endmodule

// File: rtl/gfa_mult_chk.sv
`timescale 1ns/1ps
module gfa_mult_chk #(
    parameter int M = 10
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [M-1:0] a_in,
    input logic [M-1:0] b_in,
    input logic         out_valid,
    input logic [M-1:0] product
);
    // Independent M-deep history of what entered at the ports.
    logic [M-1:0] v_sr;
    logic [M-1:0] z_sr;
    logic [M-1:0] u_sr;
    logic [M-1:0] a_sr [0:M-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            v_sr <= '0;
            z_sr <= '0;
            u_sr <= '0;
            for (int k = 0; k < M; k++) a_sr[k] <= '0;
        end else begin
            v_sr <= {v_sr[M-2:0], in_valid};
            z_sr <= {z_sr[M-2:0], (a_in == '0) || (b_in == '0)};
            u_sr <= {u_sr[M-2:0], (b_in == M'(1))};
            a_sr[0] <= a_in;
            for (int k = 1; k < M; k++) a_sr[k] <= a_sr[k-1];
        end
    end

    AST_VALID_ALIGN: assert property (@(posedge clk) disable iff (rst)
        out_valid == v_sr[M-1]);                                         // R2

    AST_VALID_KNOWN: assert property (@(posedge clk) disable iff (rst)
        !$isunknown(out_valid));                                         // R2

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!out_valid && product == '0));                          // R4

    AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (rst)
        (v_sr[M-1] && z_sr[M-1]) |-> product == '0);                     // R6

    AST_UNIT_OPERAND: assert property (@(posedge clk) disable iff (rst)
        (v_sr[M-1] && u_sr[M-1]) |-> product == a_sr[M-1]);              // R5
endmodule

bind gfa_mult gfa_mult_chk #(.M(M)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .a_in      (a_in),
    .b_in      (b_in),
    .out_valid (out_valid),
    .product   (product)
);

// File: tb/gfa_mult_test.sv
`timescale 1ns/1ps
module gfa_mult_test;
    localparam int M = 10;
    localparam int HD = 64;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [M-1:0] a_in = '0;
    logic [M-1:0] b_in = '0;
    logic         out_valid;
    logic [M-1:0] product;

    int total = 0;
    int fails = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    logic         h_v   [0:HD-1];
    logic [M-1:0] h_exp [0:HD-1];
    string        h_tag [0:HD-1];

    always #2.5 clk = ~clk;

    gfa_mult #(.M(M)) uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .a_in      (a_in),
        .b_in      (b_in),
        .out_valid (out_valid),
        .product   (product)
    );

    function automatic logic [M-1:0] ref_mul(input logic [M-1:0] a, input logic [M-1:0] b);
        logic [2*M-2:0] t;
        t = '0;
        for (int i = 0; i < M; i++) begin
            if (b[i]) t = t ^ ((2*M-1)'(a) << i);
        end
        for (int d = 2*M-2; d >= M; d--) begin
            if (t[d]) t = t ^ ((2*M-1)'({(M+1){1'b1}}) << (d - M));
        end
        return t[M-1:0];
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [M-1:0] act, input logic [M-1:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    task automatic clear_hist();
        for (int k = 0; k < HD; k++) begin
            h_v[k]   = 1'b0;
            h_exp[k] = '0;
            h_tag[k] = "R2";
        end
        cyc = 0;
    endtask

    // Called at a falling edge: check the output due now, then drive one pair.
    task automatic step(input logic [M-1:0] a, input logic [M-1:0] b, input bit v,
                        input logic [M-1:0] exp, input string tag);
        logic         ev;
        logic [M-1:0] ee;
        string        et;
        ev = 1'b0; ee = '0; et = "R2";
        if (cyc >= M) begin
            ev = h_v[(cyc - M) % HD];
            ee = h_exp[(cyc - M) % HD];
            et = h_tag[(cyc - M) % HD];
        end
        chk(out_valid === ev, "R2", "out_valid", M'(out_valid), M'(ev));
        if (ev) chk(product === ee, et, "product", product, ee);
        h_v[cyc % HD]   = v;
        h_exp[cyc % HD] = exp;
        h_tag[cyc % HD] = tag;
        a_in = a; b_in = b; in_valid = v;
        cyc++;
        @(negedge clk);
    endtask

    task automatic flush();
        for (int k = 0; k < M + 1; k++) step('0, '0, 1'b0, '0, "R2");
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(out_valid === 1'b0, "R4", "out_valid in reset", M'(out_valid), '0);
        chk(product === '0, "R4", "product in reset", product, '0);
        rst = 1'b0;
        clear_hist();
    endtask

    task automatic t_zero();
        step('0, 10'h2A5, 1'b1, '0, "R6");
        step(10'h3FF, '0, 1'b1, '0, "R6");
        step('0, '0, 1'b1, '0, "R6");
        step(10'h155, '0, 1'b1, '0, "R6");
        flush();
    endtask

    task automatic t_one();
        step(10'h2B7, 10'h001, 1'b1, 10'h2B7, "R5");
        step(10'h001, 10'h1C3, 1'b1, 10'h1C3, "R5");
        step(10'h3FF, 10'h001, 1'b1, 10'h3FF, "R5");
        step(10'h001, 10'h001, 1'b1, 10'h001, "R5");
        flush();
    endtask

    task automatic t_ones();
        step(10'h3FF, 10'h3FF, 1'b1, M'(1) << (M - 1), "R7");
        step(10'h3FF, 10'h3FF, 1'b1, ref_mul(10'h3FF, 10'h3FF), "R1");
        flush();
    endtask

    task automatic t_random();
        for (int k = 0; k < 60; k++) begin
            logic [M-1:0] a;
            logic [M-1:0] b;
            a = M'($urandom);
            b = M'($urandom);
            step(a, b, 1'b1, ref_mul(a, b), (k % 2 == 0) ? "R1" : "R3");
        end
        flush();
    endtask

    task automatic t_walk();
        for (int i = 0; i < M; i++) begin
            for (int j = 0; j < M; j++) begin
                logic [M-1:0] a;
                logic [M-1:0] b;
                a = M'(1) << i;
                b = M'(1) << j;
                step(a, b, 1'b1, ref_mul(a, b), "R1");
            end
        end
        flush();
    endtask

    task automatic t_bubbles();
        for (int k = 0; k < 30; k++) begin
            logic [M-1:0] a;
            logic [M-1:0] b;
            bit v;
            a = M'($urandom);
            b = M'($urandom);
            v = ((k % 3) != 1);
            step(a, b, v, ref_mul(a, b), "R2");
        end
        flush();
    endtask

    task automatic t_reset_mid();
        for (int k = 0; k < M - 2; k++) begin
            logic [M-1:0] a;
            a = M'($urandom);
            step(a, 10'h3C5, 1'b1, ref_mul(a, 10'h3C5), "R1");
        end
        rst = 1'b1;
        in_valid = 1'b1;
        @(negedge clk);
        chk(out_valid === 1'b0, "R4", "out_valid after mid reset", M'(out_valid), '0);
        chk(product === '0, "R4", "product after mid reset", product, '0);
        @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b0;
        clear_hist();
        flush();
    endtask

    initial begin
        clear_hist();
        t_reset();
        t_zero();
        t_one();
        t_ones();
        t_walk();
        t_random();
        t_bubbles();
        t_reset_mid();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL R3 watchdog: actual hung expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule